// File: doc/BRIEF.md
# Embedded Operation Status Read Path

This block sits between the array read port and the host read data bus of a byte-wide flash-style memory. When no embedded program or erase is running, reads return the array contents unchanged. While an operation is running, reads return a status byte instead. The host polls this byte to learn when the operation has finished.

Two status signals share the byte. The poll bit reports the inverse of the value the operation will leave behind. For a program, that value is bit 7 of the byte being written. For an erase, the final value is 1, because erased cells read as all ones. The toggle bit changes state on every read taken during the operation. Once busy falls, the array data appears again, so the poll bit takes its true value and the toggle bit stops changing. The host may start polling at any time. The operation timer and the array itself live outside this block.

Top module: `status_read_top`

## Requirements
- R1: While `busy_i` is 0, `rd_data_o` equals `array_data_i` on all 8 bits, combinationally. After a completed erase, the all-ones array therefore reads bit 7 as 1.
- R2: While `busy_i` is 1 and `erase_i` is 0, bit 7 of `rd_data_o` is the inverse of bit 7 of `prog_byte_i`.
- R3: While `busy_i` is 1 and `erase_i` is 1, bit 7 of `rd_data_o` is 0.
- R4: While `busy_i` is 1, bit 6 of `rd_data_o` shows an internal toggle state. That state inverts at each rising clock edge where both `rd_strobe_i` and `busy_i` are 1, so consecutive busy reads return alternating bit 6 values.
- R5: The toggle state holds its value at every edge where `rd_strobe_i` or `busy_i` is 0. Reads taken while idle therefore do not change the bit 6 value that the next busy read returns.
- R6: While `busy_i` is 1, bits 5 down to 0 of `rd_data_o` are 0.
- R7: Reset (`rst_n` low, asynchronous) clears the toggle state to 0, so the first busy read after reset returns bit 6 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | An embedded operation is running |
| erase_i | input | 1 | The running operation is an erase |
| prog_byte_i | input | 8 | Byte being programmed |
| rd_strobe_i | input | 1 | One read access in this cycle |
| array_data_i | input | 8 | Data read from the array |
| rd_data_o | output | 8 | Read data returned to the host |

## Verification
The bench runs program and erase operations of varied length and drives the read strobe in irregular patterns. These include back-to-back strobes, long gaps, and strobes while idle. A design that advanced the toggle on idle reads, or on busy cycles with no read, would return the wrong bit 6 phase on the next busy read. A missing erase case, or an inverted poll polarity, shows up as a wrong bit 7 in one operation type. Leftover array bits during busy reads break the zero fill. The cycle where busy falls is checked too, to confirm the array data returns at once.

// File: rtl/status_read_pkg.sv
package status_read_pkg;
   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } op_kind_e;

   // Value the poll bit shows while busy: inverse of the final cell value.
   function automatic logic poll_value(op_kind_e kind, logic final_bit);
      return (kind == OP_ERASE) ? 1'b0 : ~final_bit;
   endfunction
endpackage

// File: rtl/status_toggle.sv
module status_toggle #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   output logic state_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_o <= RST_VAL;
      else if (adv_i)
         state_o <= ~state_o;
   end
endmodule

// File: rtl/status_compose.sv
module status_compose
   import status_read_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TGL_BIT  = 6,
   parameter bit FILL_VAL = 1'b0
) (
   input  logic              busy_i,
   input  logic              erase_i,
   input  logic [DATA_W-1:0] prog_byte_i,
   input  logic [DATA_W-1:0] array_i,
   input  logic              tgl_i,
   output logic [DATA_W-1:0] data_o
);
   op_kind_e kind;
   logic     poll;

   assign kind = erase_i ? OP_ERASE : OP_PROGRAM;
   assign poll = poll_value(kind, prog_byte_i[POLL_BIT]);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
         assign data_o[i] = busy_i ? poll : array_i[i];
      end else if (i == TGL_BIT) begin : g_tgl
         assign data_o[i] = busy_i ? tgl_i : array_i[i];
      end else begin : g_fill
         assign data_o[i] = busy_i ? FILL_VAL : array_i[i];
      end
   end
endmodule

// File: rtl/status_read_top.sv
module status_read_top #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TGL_BIT  = 6,
   parameter bit TGL_RST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              erase_i,
   input  logic [DATA_W-1:0] prog_byte_i,
   input  logic              rd_strobe_i,
   input  logic [DATA_W-1:0] array_data_i,
   output logic [DATA_W-1:0] rd_data_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("status_read_top: DATA_W must be at least 2");
   end
   if (POLL_BIT < 0 || POLL_BIT >= DATA_W || TGL_BIT < 0 || TGL_BIT >= DATA_W) begin : g_bad_pos
      $error("status_read_top: status bit position out of range");
   end
   if (POLL_BIT == TGL_BIT) begin : g_bad_overlap
      $error("status_read_top: poll and toggle bits must differ");
   end

   logic tgl_adv;
   logic tgl_q;

   assign tgl_adv = busy_i & rd_strobe_i;

   status_toggle #(.RST_VAL(TGL_RST)) toggle_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (tgl_adv),
      .state_o (tgl_q)
   );

   status_compose #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT),
      .TGL_BIT  (TGL_BIT),
      .FILL_VAL (1'b0)
   ) compose_i (
      .busy_i      (busy_i),
      .erase_i     (erase_i),
      .prog_byte_i (prog_byte_i),
      .array_i     (array_data_i),
      .tgl_i       (tgl_q),
      .data_o      (rd_data_o)
   );
endmodule

// File: rtl/status_read_chk.sv
module status_read_chk #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TGL_BIT  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_i,
   input logic              erase_i,
   input logic [DATA_W-1:0] prog_byte_i,
   input logic              rd_strobe_i,
   input logic [DATA_W-1:0] array_data_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              tgl_q
);
   logic [DATA_W-1:0] fill_mask;
   always_comb begin
      fill_mask = '1;
      fill_mask[POLL_BIT] = 1'b0;
      fill_mask[TGL_BIT]  = 1'b0;
   end

   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_i |-> rd_data_o == array_data_i); // R1
   AST_POLL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !erase_i) |-> rd_data_o[POLL_BIT] != prog_byte_i[POLL_BIT]); // R2
   AST_POLL_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && erase_i) |-> !rd_data_o[POLL_BIT]); // R3
   AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && rd_strobe_i) |=> tgl_q != $past(tgl_q)); // R4
   AST_TGL_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> rd_data_o[TGL_BIT] == tgl_q); // R4
   AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_i && rd_strobe_i) |=> $stable(tgl_q)); // R5
   AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (rd_data_o & fill_mask) == '0); // R6
   always_comb begin
      if (!rst_n) AST_RESET_CLEAR: assert (tgl_q == 1'b0); // R7
   end
endmodule

bind status_read_top status_read_chk #(
   .DATA_W   (DATA_W),
   .POLL_BIT (POLL_BIT),
   .TGL_BIT  (TGL_BIT)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_i       (busy_i),
   .erase_i      (erase_i),
   .prog_byte_i  (prog_byte_i),
   .rd_strobe_i  (rd_strobe_i),
   .array_data_i (array_data_i),
   .rd_data_o    (rd_data_o),
   .tgl_q        (tgl_q)
);

// File: tb/status_read_top_tb.sv
module status_read_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       busy = 1'b0;
   logic       erase = 1'b0;
   logic [7:0] pbyte = 8'h00;
   logic       rd = 1'b0;
   logic [7:0] arr = 8'hFF;
   logic [7:0] dout;

   int checks = 0;
   int errors = 0;
   int model_tgl = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   status_read_top dut_i (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .erase_i(erase),
      .prog_byte_i(pbyte), .rd_strobe_i(rd), .array_data_i(arr),
      .rd_data_o(dout)
   );

   // reference toggle: counts busy reads, parity is the bit
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_tgl <= 0;
      else if (busy && rd) model_tgl <= model_tgl + 1;
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare full output against the reference every cycle
   task automatic compare();
      if (!busy) begin
         chk("R1", dout, arr);
      end else begin
         if (erase) chk("R3", dout[7], 0);
         else       chk("R2", dout[7], pbyte[7] ? 0 : 1);
         chk("R4 R5", dout[6], model_tgl % 2);
         chk("R6", dout[5:0], 0);
      end
   endtask

   task automatic step(bit b, bit e, bit r, logic [7:0] p, logic [7:0] a);
      @(negedge clk);
      compare();
      busy = b; erase = e; rd = r; pbyte = p; arr = a;
      #0.1 compare();
   endtask

   // one embedded operation; a counter stands in for the timer
   task automatic run_op(bit e, logic [7:0] p, int len, int rd_every);
      for (int t = 0; t < len; t++) begin
         step(1'b1, e, (rd_every == 0) ? 1'b0 : (t % rd_every == 0), p, 8'h5A);
      end
      step(1'b0, 1'b0, 1'b1, 8'h00, e ? 8'hFF : p);
      // R1: completion shows true data; erased byte reads bit 7 as 1
      chk("R1", dout[7], e ? 1 : p[7]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R7", dout, arr);
      rst_n = 1'b1;
      // R7: first busy read after reset shows bit 6 = 0
      step(1'b1, 1'b0, 1'b1, 8'h80, 8'h33);
      #0.1 chk("R7", dout[6], 0);
      step(1'b1, 1'b0, 1'b1, 8'h80, 8'h33);
      #0.1 chk("R4", dout[6], 1);
      run_op(1'b0, 8'h80, 6, 1);
      run_op(1'b0, 8'h3C, 9, 2);
      run_op(1'b1, 8'h00, 12, 3);
      // R5: idle reads do not advance the toggle
      for (int k = 0; k < 7; k++) step(1'b0, 1'b0, 1'b1, 8'h00, 8'(k * 37));
      run_op(1'b1, 8'hFF, 5, 0);
      run_op(1'b0, 8'h7F, 20, 1);
      for (int k = 0; k < 40; k++) begin
         run_op(k[0], 8'($urandom), 2 + ($urandom % 10), $urandom % 4);
         step(1'b0, 1'b0, k[1], 8'h00, 8'($urandom));
      end
      step(1'b0, 1'b0, 1'b0, 8'h00, 8'hFF);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (50000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule